// File: doc/BRIEF.md
# External Bus Power-Up Sequencer

This block brings an external parallel bus out of reset when software or a boot controller asks it to. A one-cycle start strobe, accepted only while the block is idle, sets off a fixed chain of steps. First the reset and clock output pads are enabled while the bus reset stays asserted and the bus clock stays off. Next the bus clock is switched on. The reset is then held for a timed interval and released. The on-chip arbiter is selected after that, and the block lets the bus settle before it asks for the address windows to be programmed. Once those windows report done, it waits a long final settle time and then raises a ready flag.

Every wait is given in nanoseconds and converted into clock cycles from a clock-frequency parameter, with the count always rounded up. The window programming itself is done by a neighbouring block. This block only raises a request and waits for that block's done pulse. A synchronous reset returns the sequencer to idle from any step, with every output low.

Top module: `pbus_rst_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is low after that edge: pads disabled, clock off, bus reset asserted, ready low. This holds in any step, and the block then waits in idle.
- R2: A `start` sampled high in idle sets `bus_rst_oe` and `bus_clk_oe` at the next edge, with `bus_clk_en` low and `bus_rst_n` low.
- R3: One edge after the pads are enabled, `bus_clk_en` goes high while `bus_rst_n` stays low.
- R4: `bus_rst_n` rises exactly HOLD_CYC edges after `bus_clk_en` rises. HOLD_CYC = ceil(RST_HOLD_NS * CLK_HZ / 1e9), with a minimum of 1. At 50 MHz and 150000 ns this is 7500.
- R5: `arb_int_sel` rises one edge after `bus_rst_n` rises.
- R6: `win_req` rises exactly ARB_CYC edges after `arb_int_sel` rises. ARB_CYC is rounded up in the same way, so 1010 ns at 50 MHz gives 51.
- R7: `win_req` stays high until `win_done` is sampled high and falls at that edge. A `win_done` at any other time has no effect. A `win_done` that is already high when `win_req` rises ends the request one edge later.
- R8: `ready` rises exactly RDY_CYC edges after `win_req` falls. RDY_CYC is rounded up in the same way. After that, all outputs hold their values until reset.
- R9: `start` has no effect on any output while a sequence is running or after `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin the bring-up |
| win_done | input | 1 | Window programming finished (from neighbour) |
| bus_rst_oe | output | 1 | Output enable of the bus reset pad |
| bus_clk_oe | output | 1 | Output enable of the bus clock pad |
| bus_clk_en | output | 1 | Bus clock running |
| bus_rst_n | output | 1 | Bus reset, low = asserted |
| arb_int_sel | output | 1 | Selects the on-chip bus arbiter |
| win_req | output | 1 | Request to program the address windows |
| ready | output | 1 | Bus brought up and settled |

## Verification
A scoreboard predicts every change of the seven outputs together with the exact edge on which it happens, so an off-by-one in any delay, or a step taken out of order, shows up as a mismatch. The first run answers the window request a few cycles late. Along the way it fires stray `start` and `win_done` pulses while the reset is held and after ready, which tells real transitions apart from strobes that should be ignored. A second run is cut short by a synchronous reset in the middle of the hold, which shows that the return to idle wins over the timer. A third run keeps `win_done` high from early on. That shows the done input is only taken while the request is up, and that a done which is already waiting ends the request after one cycle.

// File: rtl/pbus_rst_pkg.sv
// Package: shared step encoding and the time-to-cycle conversion used by
// the bus power-up sequencer. Assumes delays are given in nanoseconds.
package pbus_rst_pkg;

    // Steps of the bring-up, in the order they occur
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_PADS   = 4'd1,
        ST_HOLD   = 4'd2,
        ST_REL    = 4'd3,
        ST_ARB    = 4'd4,
        ST_WIN    = 4'd5,
        ST_SETTLE = 4'd6,
        ST_READY  = 4'd7
    } step_t;

    // Converts a delay in ns into clock cycles, rounding up, never below one
    function automatic longint unsigned ns_to_cycles(
        input longint unsigned dly_ns,
        input longint unsigned clk_hz
    );
        longint unsigned c;
        c = (dly_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) begin
            c = 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/pbus_rst_timer.sv
// Down-counter that times one wait step. A load pulse sets the count and
// the counter then steps down to zero and stays there. Assumes the caller
// loads N-1 to get a wait of N cycles.
module pbus_rst_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Loads on request, otherwise counts down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pbus_rst_fsm.sv
// Step controller: walks through the bring-up steps in their fixed order.
// It asks the timer to load on entry into each timed step and leaves that
// step when the timer reaches zero. Start is taken only in idle, and the
// done input only while the window request is up.
module pbus_rst_fsm
    import pbus_rst_pkg::*;
#(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] HOLD_LD = '0,
    parameter logic [CNT_W-1:0] ARB_LD  = '0,
    parameter logic [CNT_W-1:0] RDY_LD  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             win_done,
    input  logic             tmr_zero,
    output step_t            step_nxt,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    step_t step_q;

    // Chooses the following step from the current one and the inputs
    always_comb begin
        step_nxt = step_q;
        unique case (step_q)
            ST_IDLE:   if (start)    step_nxt = ST_PADS;
            ST_PADS:                 step_nxt = ST_HOLD;
            ST_HOLD:   if (tmr_zero) step_nxt = ST_REL;
            ST_REL:                  step_nxt = ST_ARB;
            ST_ARB:    if (tmr_zero) step_nxt = ST_WIN;
            ST_WIN:    if (win_done) step_nxt = ST_SETTLE;
            ST_SETTLE: if (tmr_zero) step_nxt = ST_READY;
            ST_READY:                step_nxt = ST_READY;
            default:                 step_nxt = ST_IDLE;
        endcase
    end

    // Loads the timer on entry into a timed step
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (step_nxt != step_q) begin
            unique case (step_nxt)
                ST_HOLD:   begin tmr_load = 1'b1; tmr_val = HOLD_LD; end
                ST_ARB:    begin tmr_load = 1'b1; tmr_val = ARB_LD;  end
                ST_SETTLE: begin tmr_load = 1'b1; tmr_val = RDY_LD;  end
                default:   begin tmr_load = 1'b0; tmr_val = '0;      end
            endcase
        end
    end

    // Holds the current step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
        end else begin
            step_q <= step_nxt;
        end
    end

endmodule

// File: rtl/pbus_rst_outreg.sv
// Output register: decodes the next step into the pad and control levels
// and registers them, so every output leaves a flop. Later steps keep
// what the earlier steps turned on.
module pbus_rst_outreg
    import pbus_rst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  step_t step_nxt,
    output logic  bus_rst_oe,
    output logic  bus_clk_oe,
    output logic  bus_clk_en,
    output logic  bus_rst_n,
    output logic  arb_int_sel,
    output logic  win_req,
    output logic  ready
);

    logic pads_d, clk_d, rel_d, arb_d, win_d, rdy_d;

    // Works out the level of each output in the coming step
    always_comb begin
        pads_d = (step_nxt != ST_IDLE);
        clk_d  = pads_d && (step_nxt != ST_PADS);
        rel_d  = clk_d && (step_nxt != ST_HOLD);
        arb_d  = rel_d && (step_nxt != ST_REL);
        win_d  = (step_nxt == ST_WIN);
        rdy_d  = (step_nxt == ST_READY);
    end

    // Registers the outputs and clears them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rst_oe  <= 1'b0;
            bus_clk_oe  <= 1'b0;
            bus_clk_en  <= 1'b0;
            bus_rst_n   <= 1'b0;
            arb_int_sel <= 1'b0;
            win_req     <= 1'b0;
            ready       <= 1'b0;
        end else begin
            bus_rst_oe  <= pads_d;
            bus_clk_oe  <= pads_d;
            bus_clk_en  <= clk_d;
            bus_rst_n   <= rel_d;
            arb_int_sel <= arb_d;
            win_req     <= win_d;
            ready       <= rdy_d;
        end
    end

endmodule

// File: rtl/pbus_rst_seq.sv
// Top of the external bus power-up sequencer. It works out the cycle
// counts of the three timed waits from the clock frequency and wires the
// step controller, the timer and the output register together. Assumes a
// single clock domain and a start strobe that is synchronous to it.
module pbus_rst_seq
    import pbus_rst_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 64'd50_000_000,
    parameter longint unsigned RST_HOLD_NS  = 64'd150_000,
    parameter longint unsigned ARB_WAIT_NS  = 64'd1_000,
    parameter longint unsigned RDY_WAIT_NS  = 64'd10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic win_done,
    output logic bus_rst_oe,
    output logic bus_clk_oe,
    output logic bus_clk_en,
    output logic bus_rst_n,
    output logic arb_int_sel,
    output logic win_req,
    output logic ready
);

    localparam longint unsigned HOLD_CYC = ns_to_cycles(RST_HOLD_NS, CLK_HZ);
    localparam longint unsigned ARB_CYC  = ns_to_cycles(ARB_WAIT_NS, CLK_HZ);
    localparam longint unsigned RDY_CYC  = ns_to_cycles(RDY_WAIT_NS, CLK_HZ);
    localparam longint unsigned MAX_AB   = (HOLD_CYC > ARB_CYC) ? HOLD_CYC : ARB_CYC;
    localparam longint unsigned MAX_CYC  = (MAX_AB > RDY_CYC) ? MAX_AB : RDY_CYC;
    localparam int              CNT_W    = $clog2(MAX_CYC + 1);

    step_t            step_nxt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    pbus_rst_fsm #(
        .CNT_W   (CNT_W),
        .HOLD_LD (CNT_W'(HOLD_CYC - 1)),
        .ARB_LD  (CNT_W'(ARB_CYC - 1)),
        .RDY_LD  (CNT_W'(RDY_CYC - 1))
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .win_done (win_done),
        .tmr_zero (tmr_zero),
        .step_nxt (step_nxt),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val)
    );

    pbus_rst_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pbus_rst_outreg u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_nxt    (step_nxt),
        .bus_rst_oe  (bus_rst_oe),
        .bus_clk_oe  (bus_clk_oe),
        .bus_clk_en  (bus_clk_en),
        .bus_rst_n   (bus_rst_n),
        .arb_int_sel (arb_int_sel),
        .win_req     (win_req),
        .ready       (ready)
    );

endmodule

// File: rtl/pbus_rst_seq_chk.sv
// Checker for the bus power-up sequencer. It looks only at the ports and
// uses its own window counters to time the reset hold, the arbiter settle
// and the final settle.
module pbus_rst_seq_chk #(
    parameter longint unsigned HOLD_CYC = 1,
    parameter longint unsigned ARB_CYC  = 1,
    parameter longint unsigned RDY_CYC  = 1
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic win_done,
    input logic bus_rst_oe,
    input logic bus_clk_oe,
    input logic bus_clk_en,
    input logic bus_rst_n,
    input logic arb_int_sel,
    input logic win_req,
    input logic ready
);

    logic [31:0] hold_cnt, arb_cnt, rdy_cnt;
    logic        win_seen;

    // Counts the cycles of a running clock with reset still asserted
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_clk_en || bus_rst_n) hold_cnt <= '0;
        else                                    hold_cnt <= hold_cnt + 1;
    end

    // Counts the cycles of the arbiter settle before the window request
    always_ff @(posedge clk) begin
        if (!rst_n || !arb_int_sel || win_req || win_seen) arb_cnt <= '0;
        else                                              arb_cnt <= arb_cnt + 1;
    end

    // Counts the cycles of the final settle after the request ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_seen <= 1'b0;
            rdy_cnt  <= '0;
        end else begin
            if (win_req) win_seen <= 1'b1;
            if (win_seen && !win_req && !ready) rdy_cnt <= rdy_cnt + 1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !(bus_rst_oe || bus_clk_oe || bus_clk_en || bus_rst_n ||
                     arb_int_sel || win_req || ready));

    // R2
    pads_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_oe) |-> $past(start) && bus_clk_oe && !bus_clk_en && !bus_rst_n);

    // R3
    clk_needs_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk_en |-> bus_rst_oe && bus_clk_oe);

    // R4
    hold_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_n) |-> (hold_cnt == 32'(HOLD_CYC)));

    // R4
    release_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_n |-> bus_clk_en);

    // R5
    arb_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_int_sel) |-> $past(bus_rst_n));

    // R6
    arb_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_req) |-> (arb_cnt == 32'(ARB_CYC)) && arb_int_sel);

    // R7
    req_ends_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_req) |-> $past(win_done));

    // R8
    ready_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (rdy_cnt == 32'(RDY_CYC)) && !win_req && arb_int_sel);

    // R8
    ready_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready && $stable(bus_rst_n) && $stable(arb_int_sel));

endmodule

bind pbus_rst_seq pbus_rst_seq_chk #(
    .HOLD_CYC (HOLD_CYC),
    .ARB_CYC  (ARB_CYC),
    .RDY_CYC  (RDY_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .win_done    (win_done),
    .bus_rst_oe  (bus_rst_oe),
    .bus_clk_oe  (bus_clk_oe),
    .bus_clk_en  (bus_clk_en),
    .bus_rst_n   (bus_rst_n),
    .arb_int_sel (arb_int_sel),
    .win_req     (win_req),
    .ready       (ready)
);

// File: tb/pbus_rst_seq_test.sv
// Scoreboard bench: driver tasks queue each expected change of the output
// vector with its edge number, and a monitor pops and compares as the
// changes appear.
module pbus_rst_seq_test;

    localparam int HOLD = 7500;   // 150000 ns at 50 MHz
    localparam int ARB  = 51;     // 1010 ns at 50 MHz, rounded up
    localparam int RDY  = 5000;   // 100000 ns at 50 MHz

    // Vector order: {ready, win_req, arb_int_sel, bus_rst_n, bus_clk_en, bus_clk_oe, bus_rst_oe}
    localparam logic [6:0] V_OFF    = 7'b0000000;
    localparam logic [6:0] V_PADS   = 7'b0000011;
    localparam logic [6:0] V_HOLD   = 7'b0000111;
    localparam logic [6:0] V_REL    = 7'b0001111;
    localparam logic [6:0] V_ARB    = 7'b0011111;
    localparam logic [6:0] V_WIN    = 7'b0111111;
    localparam logic [6:0] V_READY  = 7'b1011111;

    logic clk = 1'b0;
    logic rst_n, start, win_done;
    logic bus_rst_oe, bus_clk_oe, bus_clk_en, bus_rst_n, arb_int_sel, win_req, ready;

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    pbus_rst_seq #(
        .CLK_HZ      (64'd50_000_000),
        .RST_HOLD_NS (64'd150_000),
        .ARB_WAIT_NS (64'd1_010),
        .RDY_WAIT_NS (64'd100_000)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .win_done    (win_done),
        .bus_rst_oe  (bus_rst_oe),
        .bus_clk_oe  (bus_clk_oe),
        .bus_clk_en  (bus_clk_en),
        .bus_rst_n   (bus_rst_n),
        .arb_int_sel (arb_int_sel),
        .win_req     (win_req),
        .ready       (ready)
    );

    typedef struct {
        int         at;
        logic [6:0] v;
        string      req;
    } ev_t;

    ev_t  q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   mon_on = 0;
    bit   done   = 0;
    logic [6:0] prev;
    logic [6:0] vec;

    assign vec = {ready, win_req, arb_int_sel, bus_rst_n, bus_clk_en, bus_clk_oe, bus_rst_oe};

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic expect_ev(input int at, input logic [6:0] v, input string req);
        ev_t e;
        e.at = at; e.v = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: compares each change of the outputs with the queue head
    always @(negedge clk) begin
        if (mon_on && vec !== prev) begin
            if (q.size() == 0) begin
                check(1'b0, "R9", $sformatf("unexpected change at %0d: actual %b expected %b",
                                           cyc, vec, prev));
            end else begin
                ev_t e;
                e = q.pop_front();
                check(e.at == cyc && e.v === vec, e.req,
                      $sformatf("actual %b at %0d expected %b at %0d", vec, cyc, e.v, e.at));
            end
            prev = vec;
        end
    end

    // Watchdog: a hung run is counted as a failure
    always @(posedge clk) begin
        if (cyc > 60000 && !done) begin
            check(1'b0, "R8", $sformatf("watchdog actual cycle %0d expected below 60000", cyc));
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int c, w;
        rst_n = 1'b0; start = 1'b0; win_done = 1'b0;
        repeat (3) @(negedge clk);
        check(vec === V_OFF, "R1", $sformatf("reset actual %b expected %b", vec, V_OFF));
        rst_n = 1'b1;
        @(negedge clk);
        check(vec === V_OFF, "R1", $sformatf("idle actual %b expected %b", vec, V_OFF));
        prev = vec;
        mon_on = 1;

        // Run 1: late done, stray strobes during hold and after ready (R2..R9)
        @(negedge clk);
        c = cyc;
        expect_ev(c + 1, V_PADS, "R2");
        expect_ev(c + 2, V_HOLD, "R3");
        expect_ev(c + 2 + HOLD, V_REL, "R4");
        expect_ev(c + 3 + HOLD, V_ARB, "R5");
        expect_ev(c + 3 + HOLD + ARB, V_WIN, "R6");
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_cyc(c + 50);
        start = 1'b1; win_done = 1'b1;          // R9, R7: both ignored in hold
        @(negedge clk); start = 1'b0; win_done = 1'b0;
        w = c + 3 + HOLD + ARB + 5;
        wait_cyc(w);
        check(vec === V_WIN, "R7", $sformatf("request held actual %b expected %b", vec, V_WIN));
        expect_ev(w + 1, V_ARB, "R7");
        expect_ev(w + 1 + RDY, V_READY, "R8");
        win_done = 1'b1;
        @(negedge clk); win_done = 1'b0;
        wait_cyc(w + 1 + RDY + 10);
        start = 1'b1;                           // R9: ignored after ready
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        check(q.size() == 0 && vec === V_READY, "R8",
              $sformatf("after ready actual %b pending %0d expected %b pending 0", vec, q.size(), V_READY));

        // Run 2: synchronous reset in the middle of the hold (R1)
        rst_n = 1'b0;
        @(negedge clk);
        c = cyc;
        expect_ev(c, V_OFF, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        c = cyc;
        expect_ev(c + 1, V_PADS, "R2");
        expect_ev(c + 2, V_HOLD, "R3");
        expect_ev(c + 101, V_OFF, "R1");
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_cyc(c + 100);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(q.size() == 0 && vec === V_OFF, "R1",
              $sformatf("after abort actual %b pending %0d expected %b pending 0", vec, q.size(), V_OFF));

        // Run 3: done already waiting when the request rises (R7)
        @(negedge clk);
        c = cyc;
        w = c + 3 + HOLD + ARB;
        expect_ev(c + 1, V_PADS, "R2");
        expect_ev(c + 2, V_HOLD, "R3");
        expect_ev(c + 2 + HOLD, V_REL, "R4");
        expect_ev(c + 3 + HOLD, V_ARB, "R5");
        expect_ev(w, V_WIN, "R6");
        expect_ev(w + 1, V_ARB, "R7");
        expect_ev(w + 1 + RDY, V_READY, "R8");
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_cyc(c + 10);
        win_done = 1'b1;
        wait_cyc(w + 1 + RDY + 10);
        win_done = 1'b0;
        repeat (10) @(negedge clk);
        check(q.size() == 0 && vec === V_READY, "R8",
              $sformatf("final actual %b pending %0d expected %b pending 0", vec, q.size(), V_READY));

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule